// File: doc/BRIEF.md
# Link Energy-Detect Power Manager

This controller decides when an Ethernet PHY may power down its major datapath blocks. It has three states. In normal operation the datapath is powered and the link is watched. In low power the datapath is held down while the media is monitored for energy. In wake-up the PHY briefly transmits to rouse a sleeping link partner. The management interface and clock outputs are outside this block and stay active in all states.

A link that stays down for a programmable time moves the block from normal to low power. Energy on the media brings it straight back. With no energy, a sleep timer ends each low-power interval. The block then requests one wake-up transmission and returns to low power. On copper that transmission is a single fast-link-pulse burst on both pairs, ended by a done handshake. On fiber it is a timed all-zero base page. Each sleep interval is shifted by a pseudo-random amount inside an asymmetric window. This keeps two identical PHYs from waking each other in lock-step. All timing counts a 1 ms tick input, and a management enable can switch the whole mechanism off.

Top module: `link_energy_pm`

## Requirements
- R1: After reset the state output is normal (code 2'b00), and power_down, flp_req and zero_page_req are all low.
- R2: In low power (code 2'b01), energy_det high at a clock edge moves the state to normal at that edge, and power_down falls with the state change.
- R3: sleep_sel, sampled when low power is entered, sets the nominal sleep time to (sleep_sel+1) seconds: 2'b00 = 1000 ticks, 2'b01 = 2000, 2'b10 = 3000, 2'b11 = 4000.
- R4: Each low-power interval ends with entry into wake-up (code 2'b10) after a tick count that lies between the nominal value minus 80 and the nominal value plus 60. The offset is drawn afresh from a free-running 16-bit LFSR every time low power is entered, including on a return from wake-up.
- R5: In wake-up with media_fiber low, flp_req is held high and zero_page_req low until flp_done is seen. The state then returns to low power at that edge, and a new sleep interval is loaded.
- R6: In wake-up with media_fiber high, zero_page_req is high for exactly 30 ticks, flp_req stays low, and the state then returns to low power.
- R7: In normal with link_up low, the state moves to low power after (linkloss_sel+1)*1000 ticks, using the same encoding as R3. link_up high at any edge, including the edge at which the timeout would expire, reloads the timer and keeps the state normal.
- R8: With pm_en low, power_down, flp_req and zero_page_req are low in the same cycle, and the state is normal from the next edge onward.
- R9: energy_det has no effect in wake-up: the state never goes from wake-up to normal while pm_en is high.
- R10: Timers advance only on clock edges where tick_1ms is high. With the tick held low, neither the sleep timeout nor the link-loss timeout ever expires.
- R11: power_down is high exactly when the state is low power and pm_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond; all timers count it |
| pm_en | input | 1 | Power-management enable; low forces normal |
| media_fiber | input | 1 | 1 = fiber media, 0 = copper media |
| energy_det | input | 1 | Signal energy present on the media |
| link_up | input | 1 | Link status from the link layer |
| sleep_sel | input | 2 | Nominal sleep time select (1..4 s) |
| linkloss_sel | input | 2 | Link-loss timeout select (1..4 s) |
| flp_done | input | 1 | Pulse generator reports the burst finished |
| state_o | output | 2 | Current state: 00 normal, 01 low power, 10 wake-up |
| power_down | output | 1 | Power-down enable for the major datapath blocks |
| flp_req | output | 1 | Request for one fast-link-pulse burst on pairs A and B |
| zero_page_req | output | 1 | Request to send the all-zero base page |

## Verification
The sharpest collision is link recovery landing on the very tick at which the link-loss timeout expires. Recovery must win, and the block must stay in normal. The bench drops the link, lets exactly one tick fewer than the timeout go by, and raises link_up so that it is sampled on the expiring edge. It then checks that the state is still normal, and still normal well past the original deadline. A second overlap is energy arriving during wake-up while the burst handshake is still pending. The bench holds energy_det high through a copper wake-up and judges that the state stays in wake-up with the request held.

// File: rtl/pm_pkg.sv
// Package: shared state encoding for the link energy-detect power manager.
// Assumes: the state code is also driven out on a port, so the values are fixed.
package pm_pkg;
    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_LOWPWR = 2'b01,
        PM_WAKEUP = 2'b10
    } pm_state_e;
endpackage

// File: rtl/pm_lfsr.sv
// Module: pm_lfsr
// Free-running Galois LFSR that supplies the sleep-interval jitter.
// Assumes: SEED is nonzero and TAPS is a maximal-length mask for W bits.
module pm_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'h5A3C
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    // Shift every cycle; the seed is loaded at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= SEED;
        else
            value <= (value >> 1) ^ (value[0] ? TAPS : '0);
    end
endmodule

// File: rtl/pm_timer.sv
// Module: pm_timer
// Shared millisecond down-counter. A load wins over counting. expire is high
// when the tick that brings the count to zero arrives, so a load of N expires
// on the Nth tick after the load.
// Assumes: loads are never zero; only one timed activity runs at a time.
module pm_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    // Expiry is flagged on the tick that would take the count to zero.
    assign expire = tick && (cnt <= CW'(1));

    // Load on request, otherwise count down one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/pm_fsm.sv
// Module: pm_fsm
// State sequencer. It picks the next state, tells the shared timer what to load,
// and decodes the power-down and wake-up request outputs.
// Priorities: disable > link up > link-loss expiry in normal, and
// energy > sleep expiry in low power. Energy is not looked at in wake-up.
// Assumes: rand_val changes every cycle; media_fiber is stable during a wake-up.
module pm_fsm
    import pm_pkg::*;
#(
    parameter int TPS      = 1000,
    parameter int NEG_MS   = 80,
    parameter int POS_MS   = 60,
    parameter int FIBER_MS = 30,
    parameter int RW       = 16,
    parameter int CW       = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pm_en,
    input  logic          media_fiber,
    input  logic          energy_det,
    input  logic          link_up,
    input  logic [1:0]    sleep_sel,
    input  logic [1:0]    linkloss_sel,
    input  logic          flp_done,
    input  logic          tmr_expire,
    input  logic [RW-1:0] rand_val,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output pm_state_e     state,
    output logic          power_down,
    output logic          flp_req,
    output logic          zero_page_req
);
    localparam int SPAN = NEG_MS + POS_MS + 1;

    pm_state_e     nxt;
    logic          armed;
    logic [CW-1:0] sleep_val;
    logic [CW-1:0] loss_val;

    // Timer reload values: nominal sleep plus jitter, and the link-loss timeout.
    always_comb begin
        sleep_val = CW'((int'(sleep_sel) + 1) * TPS + int'(rand_val % RW'(SPAN)) - NEG_MS);
        loss_val  = CW'((int'(linkloss_sel) + 1) * TPS);
    end

    // Next-state and timer-load decision.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = loss_val;
        if (!pm_en) begin
            nxt      = PM_NORMAL;
            tmr_load = 1'b1;
        end else begin
            case (state)
                PM_NORMAL: begin
                    if (link_up || !armed) begin
                        tmr_load = 1'b1;
                    end else if (tmr_expire) begin
                        nxt      = PM_LOWPWR;
                        tmr_load = 1'b1;
                        tmr_val  = sleep_val;
                    end
                end
                PM_LOWPWR: begin
                    if (energy_det) begin
                        nxt      = PM_NORMAL;
                        tmr_load = 1'b1;
                    end else if (tmr_expire) begin
                        nxt      = PM_WAKEUP;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(FIBER_MS);
                    end
                end
                PM_WAKEUP: begin
                    if (media_fiber ? tmr_expire : flp_done) begin
                        nxt      = PM_LOWPWR;
                        tmr_load = 1'b1;
                        tmr_val  = sleep_val;
                    end
                end
                default: begin
                    nxt      = PM_NORMAL;
                    tmr_load = 1'b1;
                end
            endcase
        end
    end

    // State register; armed forces one timer load in the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PM_NORMAL;
            armed <= 1'b0;
        end else begin
            state <= nxt;
            armed <= 1'b1;
        end
    end

    // Output decode, gated by the enable so that disabling takes effect at once.
    always_comb begin
        power_down    = pm_en && (state == PM_LOWPWR);
        flp_req       = pm_en && (state == PM_WAKEUP) && !media_fiber;
        zero_page_req = pm_en && (state == PM_WAKEUP) && media_fiber;
    end
endmodule

// File: rtl/link_energy_pm.sv
// Module: link_energy_pm (top)
// Energy-detect power manager for an Ethernet PHY: normal / low power / wake-up.
// Assumes: tick_1ms is a one-cycle pulse; energy_det and link_up are already
// synchronous to clk; the pulse generator answers flp_req with flp_done.
module link_energy_pm
    import pm_pkg::*;
#(
    parameter int          TICKS_PER_S = 1000,
    parameter int          OFFSET_NEG  = 80,
    parameter int          OFFSET_POS  = 60,
    parameter int          FIBER_MS    = 30,
    parameter int          LFSR_W      = 16,
    parameter logic [15:0] LFSR_TAPS   = 16'hB400,
    parameter logic [15:0] LFSR_SEED   = 16'h5A3C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       pm_en,
    input  logic       media_fiber,
    input  logic       energy_det,
    input  logic       link_up,
    input  logic [1:0] sleep_sel,
    input  logic [1:0] linkloss_sel,
    input  logic       flp_done,
    output logic [1:0] state_o,
    output logic       power_down,
    output logic       flp_req,
    output logic       zero_page_req
);
    localparam int MAXV = 4 * TICKS_PER_S + OFFSET_POS;
    localparam int CW   = $clog2(MAXV + 1);

    logic [LFSR_W-1:0] rand_val;
    logic              tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              tmr_expire;
    pm_state_e         state;

    pm_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_W'(LFSR_TAPS)),
        .SEED (LFSR_W'(LFSR_SEED))
    ) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rand_val)
    );

    pm_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1ms),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    pm_fsm #(
        .TPS      (TICKS_PER_S),
        .NEG_MS   (OFFSET_NEG),
        .POS_MS   (OFFSET_POS),
        .FIBER_MS (FIBER_MS),
        .RW       (LFSR_W),
        .CW       (CW)
    ) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pm_en         (pm_en),
        .media_fiber   (media_fiber),
        .energy_det    (energy_det),
        .link_up       (link_up),
        .sleep_sel     (sleep_sel),
        .linkloss_sel  (linkloss_sel),
        .flp_done      (flp_done),
        .tmr_expire    (tmr_expire),
        .rand_val      (rand_val),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .state         (state),
        .power_down    (power_down),
        .flp_req       (flp_req),
        .zero_page_req (zero_page_req)
    );

    assign state_o = state;
endmodule

// File: rtl/pm_checker.sv
// Module: pm_checker
// Property checker for link_energy_pm, attached with bind.
// Assumes: state codes 00 normal, 01 low power, 10 wake-up.
module pm_checker #(
    parameter int TPS    = 1000,
    parameter int POS_MS = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1ms,
    input logic       pm_en,
    input logic       media_fiber,
    input logic       energy_det,
    input logic       link_up,
    input logic [1:0] sleep_sel,
    input logic [1:0] linkloss_sel,
    input logic       flp_done,
    input logic [1:0] state_o,
    input logic       power_down,
    input logic       flp_req,
    input logic       zero_page_req
);
    localparam int LP_MAX = 4 * TPS + POS_MS;
    int lp_ticks;

    // Count the ticks spent in the current low-power interval.
    always_ff @(posedge clk) begin
        if (!rst_n || state_o != 2'b01)
            lp_ticks <= 0;
        else if (tick_1ms)
            lp_ticks <= lp_ticks + 1;
    end

    a_r2_energy_exits_lp: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en && state_o == 2'b01 && energy_det |=> state_o == 2'b00);
    a_r4_sleep_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b01 |-> lp_ticks <= LP_MAX);
    a_r5_flp_done_returns: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en && state_o == 2'b10 && !media_fiber && flp_done |=> state_o == 2'b01);
    a_r7_link_holds_normal: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en && state_o == 2'b00 && link_up |=> state_o == 2'b00);
    a_r8_disable_forces_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_en |=> state_o == 2'b00);
    a_r8_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_en |-> !power_down && !flp_req && !zero_page_req);
    a_r9_no_wake_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en && state_o == 2'b10 |=> state_o != 2'b00);
    a_r10_no_tick_stays_lp: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en && state_o == 2'b01 && !tick_1ms && !energy_det |=> state_o == 2'b01);
    a_r11_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b11);
endmodule

bind link_energy_pm pm_checker #(.TPS(TICKS_PER_S), .POS_MS(OFFSET_POS)) i_chk (.*);

// File: tb/test_link_energy_pm.sv
// Bench: directed scenarios, one task each. Inputs are driven and outputs
// sampled on the falling edge. tick_1ms is pulsed every cycle to compress time.
module test_link_energy_pm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b1;
    logic       pm_en = 1'b1;
    logic       media_fiber = 1'b0;
    logic       energy_det = 1'b0;
    logic       link_up = 1'b0;
    logic [1:0] sleep_sel = 2'b01;
    logic [1:0] linkloss_sel = 2'b00;
    logic       flp_done = 1'b0;
    logic [1:0] state_o;
    logic       power_down, flp_req, zero_page_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    localparam logic [1:0] ST_N = 2'b00, ST_L = 2'b01, ST_W = 2'b10;

    always #4 clk = ~clk;

    link_energy_pm i_link_energy_pm (.*);

    // Record one check and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Record one range check.
    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // Wait until the state equals st; returns the number of falling edges waited.
    task automatic wait_state(input logic [1:0] st, input int limit, output int n);
        n = 0;
        while (state_o != st && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        chk("R1 state", int'(state_o), int'(ST_N));
        chk("R1 power_down", int'(power_down), 0);
        chk("R1 requests", int'(flp_req | zero_page_req), 0);
    endtask

    // Link drop to low power after the selected timeout.
    task automatic t_linkloss(input logic [1:0] sel);
        int n;
        linkloss_sel = sel;
        link_up = 1'b1;
        repeat (5) @(negedge clk);
        link_up = 1'b0;
        wait_state(ST_L, 10000, n);
        chk("R7 linkloss ticks", n, (int'(sel) + 1) * 1000);
        chk("R11 power_down in LP", int'(power_down), 1);
    endtask

    // Energy in low power wakes to normal at the next edge.
    task automatic t_energy();
        energy_det = 1'b1;
        @(negedge clk);
        chk("R2 energy to normal", int'(state_o), int'(ST_N));
        chk("R2 power_down off", int'(power_down), 0);
        energy_det = 1'b0;
    endtask

    // A brief link return restarts the full timeout.
    task automatic t_recover();
        int n;
        linkloss_sel = 2'b01;
        link_up = 1'b1;
        repeat (5) @(negedge clk);
        link_up = 1'b0;
        repeat (500) @(negedge clk);
        chk("R7 still normal mid-timeout", int'(state_o), int'(ST_N));
        link_up = 1'b1;
        repeat (5) @(negedge clk);
        link_up = 1'b0;
        wait_state(ST_L, 10000, n);
        chk("R7 timer cleared by link", n, 2000);
    endtask

    // Measure one low-power interval from its first cycle; must end in wake-up.
    task automatic t_sleep(input logic [1:0] sel, input string req);
        int n = 1;
        int pd_bad = 0;
        while (state_o == ST_L && n < 10000) begin
            if (!power_down) pd_bad++;
            @(negedge clk);
            if (state_o == ST_L) n++;
        end
        chk_rng(req, n, (int'(sel) + 1) * 1000 - 80, (int'(sel) + 1) * 1000 + 60);
        chk("R11 power_down through LP", pd_bad, 0);
        chk("R4 ends in wakeup", int'(state_o), int'(ST_W));
        chk("R11 power_down off in wakeup", int'(power_down), 0);
    endtask

    // Copper wake-up: request held, energy ignored, done returns to low power.
    task automatic t_copper(input logic [1:0] next_sel);
        chk("R5 flp_req", int'(flp_req), 1);
        chk("R5 no zero page", int'(zero_page_req), 0);
        energy_det = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 energy ignored in wakeup", int'(state_o), int'(ST_W));
        chk("R5 request held", int'(flp_req), 1);
        energy_det = 1'b0;
        sleep_sel = next_sel;
        flp_done = 1'b1;
        @(negedge clk);
        flp_done = 1'b0;
        chk("R5 back to LP", int'(state_o), int'(ST_L));
        chk("R5 request dropped", int'(flp_req), 0);
    endtask

    // Fiber wake-up: zero page requested for exactly 30 ticks.
    task automatic t_fiber();
        int n = 0;
        int flp_seen = 0;
        while (state_o == ST_W && n < 1000) begin
            if (zero_page_req) n++;
            if (flp_req) flp_seen++;
            @(negedge clk);
        end
        chk("R6 zero page ticks", n, 30);
        chk("R6 no flp on fiber", flp_seen, 0);
        chk("R6 back to LP", int'(state_o), int'(ST_L));
    endtask

    // Without ticks the sleep timer never expires.
    task automatic t_tick();
        tick_1ms = 1'b0;
        repeat (5000) @(negedge clk);
        chk("R10 no tick stays LP", int'(state_o), int'(ST_L));
        tick_1ms = 1'b1;
    endtask

    // Disable from low power and from wake-up.
    task automatic t_disable();
        int n;
        pm_en = 1'b0;
        #1;
        chk("R8 power_down off at once", int'(power_down), 0);
        @(negedge clk);
        chk("R8 forced normal", int'(state_o), int'(ST_N));
        repeat (3000) @(negedge clk);
        chk("R8 stays normal", int'(state_o), int'(ST_N));
        pm_en = 1'b1;
        media_fiber = 1'b0;
        sleep_sel = 2'b00;
        wait_state(ST_W, 10000, n);
        chk("R8 reached wakeup", int'(state_o), int'(ST_W));
        pm_en = 1'b0;
        #1;
        chk("R8 flp_req off at once", int'(flp_req), 0);
        @(negedge clk);
        chk("R8 wakeup forced normal", int'(state_o), int'(ST_N));
        pm_en = 1'b1;
    endtask

    // Link returns on the very tick the timeout would expire.
    task automatic t_race();
        linkloss_sel = 2'b00;
        link_up = 1'b1;
        repeat (5) @(negedge clk);
        link_up = 1'b0;
        repeat (999) @(negedge clk);
        link_up = 1'b1;
        @(negedge clk);
        chk("R7 recovery wins at expiry", int'(state_o), int'(ST_N));
        repeat (1500) @(negedge clk);
        chk("R7 still normal after deadline", int'(state_o), int'(ST_N));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linkloss(2'b00);
        t_energy();
        sleep_sel = 2'b01;
        t_recover();
        t_sleep(2'b01, "R4 sleep window sel=01");
        t_copper(2'b11);
        t_sleep(2'b11, "R3 sleep window sel=11");
        t_copper(2'b00);
        media_fiber = 1'b1;
        t_sleep(2'b00, "R3 sleep window sel=00");
        t_fiber();
        t_tick();
        t_disable();
        t_race();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule